// File: doc/BRIEF.md
# Auto-Precharge Command Spacing Monitor

This block watches the decoded command stream of a four-bank DDR memory, one command per clock, and flags commands that come too soon after a read or write that carries an auto-precharge request. For a command to a different bank, the minimum distance depends on the pair of commands. It is computed from the current burst length, CAS latency and write-to-read turnaround. These settings arrive as live inputs, so a controller can change them between traffic phases.

The monitor also follows the self-timed precharge that a write with auto precharge starts. Its bank is marked busy until the write-recovery-plus-precharge time has run out. Any bank command aimed at that bank while it is busy is reported. Each violation produces a one-cycle pulse and a code that names the reference command and the offending command.

Top module: `ap_spacing_monitor`

## Requirements
- R1: While reset is low and on the first cycle after it, `viol`, `viol_code` and `bank_busy` are all zero.
- R2: A read on a bank other than the reference bank comes at least 1 + BL/2 + tWTR clocks after a write-with-auto-precharge reference, or it is flagged.
- R3: A write on another bank comes at least BL/2 clocks after a write-with-auto-precharge reference, or it is flagged.
- R4: A read on another bank comes at least BL/2 clocks after a read-with-auto-precharge reference, or it is flagged.
- R5: A write on another bank comes at least CL + BL/2 clocks after a read-with-auto-precharge reference, or it is flagged.
- R6: An activate or precharge on another bank needs only a 1-clock gap, so it is never flagged for spacing.
- R7: Only the most recent read or write that carries auto precharge is the reference. Plain reads and writes leave it unchanged. A command to the reference bank itself is not checked for spacing.
- R8: A write with auto precharge to bank b, issued at edge e, makes `bank_busy[b]` high for commands at edges e+1 through e+tDAL-1. An activate, read, write or precharge to a busy bank is flagged with bit 4 of the code set.
- R9: `viol` pulses in the cycle after the offending command. The code is {same_bank, ref[1:0], cmd[1:0]}. For ref, 01 is read-AP and 10 is write-AP. For cmd, 00 is read, 01 is write, 10 is activate and 11 is precharge. The code is zero when `viol` is low.
- R10: The gap counter saturates, so a reference that is older than its window never produces a violation, even with BL=8, CL=7 and tWTR=7.
- R11: NOP (op 0), refresh (5), mode-register set (6) and burst stop (7) are never flagged and do not change the reference or any busy state. Op codes 1 to 4 are activate, read, write and precharge, and `cmd_ap` matters only on reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_op | input | 3 | Command: 0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 REF, 6 MRS, 7 BST |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on RD/WR |
| burst_len | input | 4 | Burst length, 2, 4 or 8 |
| cas_lat | input | 3 | CAS latency in clocks |
| t_wtr | input | 3 | Write-to-read turnaround in clocks |
| t_dal | input | 5 | Write recovery plus precharge in clocks |
| viol | output | 1 | Violation pulse |
| viol_code | output | 5 | {same_bank, ref type, command type} |
| bank_busy | output | 4 | Bank is in its self-timed write precharge |

## Verification
The bench targets the exact boundary of each window, testing one clock below the limit and exactly at it. A design that is off by one would then flag legal traffic or miss the last illegal clock. It issues a plain read or write between a reference and a later command. A design that wrongly replaced the reference would use the shorter window and miss the violation. It ends the busy window at tDAL - 1 and sends refresh and mode-register commands into a busy bank. This exposes a busy flag that lasts too long or too short, and a decoder that flags non-bank commands. A long random stretch with the largest settings shows whether a counter that wrapped instead of saturating raises late false alarms.

// File: rtl/ap_spacing_monitor.sv
module ap_spacing_monitor #(
  parameter int BANK_W = 2,
  parameter int LAT_W  = 3,
  parameter int DAL_W  = 5,
  parameter int GAP_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic [3:0]        burst_len,
  input  logic [LAT_W-1:0]  cas_lat,
  input  logic [LAT_W-1:0]  t_wtr,
  input  logic [DAL_W-1:0]  t_dal,
  output logic              viol,
  output logic [4:0]        viol_code,
  output logic [(1<<BANK_W)-1:0] bank_busy
);
  localparam int NB = 1 << BANK_W;
  localparam int MW = LAT_W + 5;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  wire is_act = cmd_op == 3'd1;
  wire is_rd  = cmd_op == 3'd2;
  wire is_wr  = cmd_op == 3'd3;
  wire is_pre = cmd_op == 3'd4;
  wire bank_cmd = is_act | is_rd | is_wr | is_pre;
  wire ap_ref = (is_rd | is_wr) & cmd_ap;

  logic              ref_vld, ref_wr;
  logic [BANK_W-1:0] ref_bank;
  logic [GAP_W-1:0]  gap;
  logic [MW-1:0]     half_bl, min_gap;
  logic [1:0]        op_cls;

  assign half_bl = MW'(burst_len >> 1);

  always_comb begin
    min_gap = MW'(1);
    if (is_rd) min_gap = ref_wr ? MW'(1) + half_bl + MW'(t_wtr) : half_bl;
    else if (is_wr) min_gap = ref_wr ? half_bl : MW'(cas_lat) + half_bl;
  end

  always_comb begin
    op_cls = 2'd3;
    if (is_rd) op_cls = 2'd0;
    else if (is_wr) op_cls = 2'd1;
    else if (is_act) op_cls = 2'd2;
  end

  wire same_bad = bank_cmd & bank_busy[cmd_bank];
  wire space_bad = ref_vld & bank_cmd & (cmd_bank != ref_bank) & (MW'(gap) < min_gap);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_vld   <= 1'b0;
      ref_wr    <= 1'b0;
      ref_bank  <= '0;
      gap       <= '0;
      viol      <= 1'b0;
      viol_code <= '0;
    end else begin
      viol <= same_bad | space_bad;
      if (same_bad)       viol_code <= {1'b1, 2'b10, op_cls};
      else if (space_bad) viol_code <= {1'b0, ref_wr ? 2'b10 : 2'b01, op_cls};
      else                viol_code <= '0;
      if (ap_ref) begin
        ref_vld  <= 1'b1;
        ref_wr   <= is_wr;
        ref_bank <= cmd_bank;
        gap      <= GAP_W'(1);
      end else if (gap != GAP_MAX) begin
        gap <= gap + GAP_W'(1);
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DAL_W-1:0] dal_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) dal_cnt <= '0;
      else if (is_wr && cmd_ap && cmd_bank == BANK_W'(b))
        dal_cnt <= (t_dal == '0) ? '0 : t_dal - DAL_W'(1);
      else if (dal_cnt != '0)
        dal_cnt <= dal_cnt - DAL_W'(1);
    end
    assign bank_busy[b] = dal_cnt != '0;

    // R8
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_busy[b]) |-> $past(is_wr && cmd_ap && cmd_bank == BANK_W'(b)));
  end

  // R9
  code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol |-> viol_code == 5'd0);

  // R11
  nonbank_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> $past(cmd_op inside {3'd1, 3'd2, 3'd3, 3'd4}));

  // R8
  same_bank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && viol_code[4]) |-> $past(bank_busy[cmd_bank]));

  // R6
  actpre_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_code[4]) |-> !viol_code[1]);
endmodule

// File: tb/ap_spacing_monitor_tb_top.sv
module ap_spacing_monitor_tb_top;
  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_op = 0;
  logic [1:0] cmd_bank = 0;
  logic cmd_ap = 0;
  logic [3:0] burst_len = 4;
  logic [2:0] cas_lat = 3, t_wtr = 2;
  logic [4:0] t_dal = 5;
  logic viol;
  logic [4:0] viol_code;
  logic [3:0] bank_busy;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit started = 0;

  always #10 clk = ~clk;

  ap_spacing_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_ap(cmd_ap),
    .burst_len(burst_len), .cas_lat(cas_lat), .t_wtr(t_wtr), .t_dal(t_dal),
    .viol(viol), .viol_code(viol_code), .bank_busy(bank_busy));

  // behavioural reference model
  int cyc = 0, ref_e = 0, ref_b = 0, busy_until[4];
  bit ref_v = 0, ref_w = 0;
  logic e_viol = 0;
  logic [4:0] e_code = 0;
  logic [3:0] e_busy = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_v = 0; ref_w = 0; cyc = 0;
      foreach (busy_until[i]) busy_until[i] = 0;
      e_viol = 0; e_code = 0; e_busy = 0;
    end else begin
      int op, b, g, mn, cls;
      bit bk, same, sp;
      cyc++;
      op = cmd_op; b = cmd_bank;
      bk = op >= 1 && op <= 4;
      cls = (op == 2) ? 0 : (op == 3) ? 1 : (op == 1) ? 2 : 3;
      same = bk && cyc < busy_until[b];
      g = cyc - ref_e;
      if (op == 2) mn = ref_w ? 1 + burst_len / 2 + t_wtr : burst_len / 2;
      else if (op == 3) mn = ref_w ? burst_len / 2 : cas_lat + burst_len / 2;
      else mn = 1;
      sp = ref_v && bk && b != ref_b && g < mn;
      e_viol = same || sp;
      if (same) e_code = 5'(16 + 8 + cls);
      else if (sp) e_code = 5'((ref_w ? 8 : 4) + cls);
      else e_code = 0;
      if (op == 3 && cmd_ap) busy_until[b] = cyc + t_dal;
      if ((op == 2 || op == 3) && cmd_ap) begin
        ref_v = 1; ref_w = (op == 3); ref_b = b; ref_e = cyc;
      end
      for (int i = 0; i < 4; i++) e_busy[i] = (cyc + 1 < busy_until[i]);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started) begin
    check(tag, viol, e_viol, "viol");
    check(tag, viol_code, e_code, "viol_code");
    check(tag, bank_busy, e_busy, "bank_busy");
  end

  task automatic issue(int op, int b, bit ap);
    @(negedge clk);
    cmd_op = 3'(op); cmd_bank = 2'(b); cmd_ap = ap;
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) issue(0, 0, 0);
  endtask

  task automatic after(int g, int op, int b, bit ap);
    nops(g - 1);
    issue(op, b, ap);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {viol, viol_code, bank_busy}, 0, "reset outputs");
    rst_n = 1;
    @(negedge clk);
    check("R1", {viol, viol_code, bank_busy}, 0, "first cycle after reset");
    started = 1;

    tag = "R2"; // min 1+2+2=5
    issue(3, 0, 1); after(4, 2, 1, 0); nops(40);
    issue(3, 0, 1); after(5, 2, 1, 0); nops(40);
    tag = "R3"; // min 2
    issue(3, 0, 1); after(1, 3, 2, 0); nops(40);
    issue(3, 1, 1); after(2, 3, 3, 0); nops(40);
    tag = "R4"; // min 2
    issue(2, 0, 1); after(1, 2, 1, 0); nops(40);
    issue(2, 0, 1); after(2, 2, 1, 1); nops(40);
    tag = "R5"; // min 3+2=5
    issue(2, 2, 1); after(4, 3, 3, 0); nops(40);
    issue(2, 2, 1); after(5, 3, 3, 0); nops(40);
    tag = "R6";
    issue(3, 0, 1); after(1, 1, 1, 0); after(1, 4, 2, 0); nops(40);
    tag = "R7";
    issue(2, 0, 1); after(2, 2, 1, 0); after(1, 3, 1, 0); after(1, 2, 0, 0); nops(40);
    tag = "R8"; // tDAL 5
    issue(3, 3, 1); after(2, 1, 3, 0); after(2, 2, 3, 0); after(1, 1, 3, 0); nops(40);
    issue(3, 1, 1); after(4, 4, 1, 0); nops(40);
    tag = "R11";
    issue(3, 2, 1); after(1, 5, 2, 0); after(1, 6, 2, 1); after(1, 7, 2, 0);
    after(1, 1, 3, 1); after(1, 0, 2, 1); nops(40);
    tag = "R10";
    burst_len = 8; cas_lat = 7; t_wtr = 7; t_dal = 9; nops(2);
    issue(3, 0, 1); after(40, 2, 1, 0); nops(40);
    issue(2, 0, 1); after(10, 3, 1, 0); after(60, 3, 2, 0); nops(40);
    tag = "R9";
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 9);
      issue(r > 7 ? 0 : r, $urandom_range(0, 3), $urandom_range(0, 1) == 1);
      if (i == 300) begin burst_len = 2; cas_lat = 3; t_wtr = 1; t_dal = 4; end
    end
    nops(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule